// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block produces the word address and per-byte write enables for a synchronous burst SRAM array. A start strobe, either of two equivalent inputs, captures an external address when all three chip enables are in their active states. Afterwards each advance pulse steps the two low address bits through a group of four words, while the upper bits stay fixed.

The step order is set at load time by an order input. When the input is low the order is interleaved: the low bits are the start bits XOR the step count. When it is high the order is linear: the low bits are the start bits plus the count, modulo four. A fresh address may be strobed in on every cycle, so the burst sequence is optional.

Writes are decoded in the same cycle as the address. A byte-write enable with per-lane selects writes only the chosen lanes. A global-write input writes every lane whatever the byte controls say.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is zero, active_o is 0 and byte_we_o is all zeros.
- R2: A clock edge with strobe_p_i or strobe_c_i high and en_a_i=1, en_b_i=1, en_c_ni=0 makes addr_o equal to addr_i and active_o equal to 1 after that edge.
- R3: Strobes on consecutive cycles each load their own address, with no idle cycle between them.
- R4: A strobe while any chip enable is inactive clears active_o and leaves addr_o unchanged.
- R5: With lin_order_i=0 at load, the k-th advance gives addr_o[1:0] = start[1:0] XOR k (mod 4).
- R6: With lin_order_i=1 at load, the k-th advance gives addr_o[1:0] = (start[1:0] + k) mod 4.
- R7: The fourth advance returns the low bits to their start value, and addr_o[ADDR_W-1:2] does not change without a new load.
- R8: addr_o holds when adv_i is low, and adv_i has no effect while active_o is 0.
- R9: The order is sampled only at load, so a change on lin_order_i during a burst does not alter the sequence.
- R10: With wr_byte_i=1 and wr_all_i=0 on a cycle that leaves active_o at 1, byte_we_o[i] equals byte_sel_i[i] after that edge (bit i = byte lane i).
- R11: wr_all_i=1 on such a cycle sets every bit of byte_we_o, whatever wr_byte_i and byte_sel_i are.
- R12: byte_we_o is all zeros after any edge that leaves active_o at 0, and after any edge where neither wr_byte_i nor wr_all_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External start address |
| strobe_p_i | input | 1 | Burst start strobe A |
| strobe_c_i | input | 1 | Burst start strobe B |
| adv_i | input | 1 | Step to the next burst address |
| lin_order_i | input | 1 | 1 = linear order, 0 = interleaved |
| en_a_i | input | 1 | Chip enable, active high |
| en_b_i | input | 1 | Chip enable, active high |
| en_c_ni | input | 1 | Chip enable, active low |
| wr_byte_i | input | 1 | Byte-write enable |
| wr_all_i | input | 1 | Global write, all lanes |
| byte_sel_i | input | NUM_BYTES | Per-lane write selects |
| addr_o | output | ADDR_W | Current word address |
| active_o | output | 1 | A burst is selected |
| byte_we_o | output | NUM_BYTES | Per-lane write enables |

## Verification
Every output is registered, so each result belongs to the one rising edge that captures its inputs. It can be seen right after that edge and stays until the next one. The bench changes inputs and samples outputs 2 ns after a rising edge. This way each check reads exactly the edge it means to test, and no value is read during an edge. Burst sequences are checked one step at a time. The expected low bits come from the start bits and the step count, and the wrap to the start value is checked on the fourth step.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;

  function automatic logic [1:0] burst_low(input burst_order_e ord,
                                           input logic [1:0] start,
                                           input logic [1:0] cnt);
    logic [1:0] sum;
    sum = start + cnt;
    return (ord == ORD_LINEAR) ? sum : (start ^ cnt);
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q, cnt_q;
  burst_order_e    ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      ord_q   <= ORD_INTLV;
    end else if (load_i) begin
      hi_q    <= addr_i[ADDR_W-1:2];
      start_q <= addr_i[1:0];
      cnt_q   <= '0;
      ord_q   <= burst_order_e'(order_i);
    end else if (step_i) begin
      cnt_q   <= cnt_q + 2'd1;  // wraps inside group of four
    end
  end

  assign addr_o = {hi_q, burst_low(ord_q, start_q, cnt_q)};

  p_load_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(addr_o));
  p_upper_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:2]));
  p_linear_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && ord_q == ORD_LINEAR) |=> addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1));
endmodule

// File: rtl/wr_decode.sv
module wr_decode #(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 wr_byte_i,
  input  logic                 wr_all_i,
  input  logic [NUM_BYTES-1:0] sel_i,
  output logic [NUM_BYTES-1:0] byte_we_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_we_o[g] <= 1'b0;
      else         byte_we_o[g] <= en_i & (wr_all_i | (wr_byte_i & sel_i[g]));
    end
  end

  p_global_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_all_i) |=> &byte_we_o);
  p_no_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || (!wr_all_i && !wr_byte_i)) |=> byte_we_o == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 strobe_p_i,
  input  logic                 strobe_c_i,
  input  logic                 adv_i,
  input  logic                 lin_order_i,
  input  logic                 en_a_i,
  input  logic                 en_b_i,
  input  logic                 en_c_ni,
  input  logic                 wr_byte_i,
  input  logic                 wr_all_i,
  input  logic [NUM_BYTES-1:0] byte_sel_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 active_o,
  output logic [NUM_BYTES-1:0] byte_we_o
);
  logic ce_all, strobe, load, desel, step, active_d, active_q;

  assign ce_all   = en_a_i & en_b_i & ~en_c_ni;
  assign strobe   = strobe_p_i | strobe_c_i;
  assign load     = strobe & ce_all;
  assign desel    = strobe & ~ce_all;
  assign step     = active_q & adv_i & ~strobe;  // strobe wins over advance
  assign active_d = load | (active_q & ~desel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  assign active_o = active_q;

  burst_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .order_i (lin_order_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o)
  );

  wr_decode #(.NUM_BYTES(NUM_BYTES)) i_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active_d),
    .wr_byte_i (wr_byte_i),
    .wr_all_i  (wr_all_i),
    .sel_i     (byte_sel_i),
    .byte_we_o (byte_we_o)
  );

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && ce_all) |=> active_o);
  p_deselect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !ce_all) |=> (!active_o && $stable(addr_o)));
  p_idle_adv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !strobe) |=> $stable(addr_o));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;
  localparam int NB = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strobe_p_i = 0, strobe_c_i = 0, adv_i = 0, lin_order_i = 0;
  logic          en_a_i = 1, en_b_i = 1, en_c_ni = 0;
  logic          wr_byte_i = 0, wr_all_i = 0;
  logic [NB-1:0] byte_sel_i = '0;
  logic [AW-1:0] addr_o;
  logic          active_o;
  logic [NB-1:0] byte_we_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW), .NUM_BYTES(NB)) i_burst_addr_gen (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic idle();
    strobe_p_i = 0; strobe_c_i = 0; adv_i = 0;
    wr_byte_i = 0; wr_all_i = 0; byte_sel_i = '0;
    en_a_i = 1; en_b_i = 1; en_c_ni = 0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic lin, input bit use_c);
    idle();
    addr_i = a; lin_order_i = lin;
    if (use_c) strobe_c_i = 1; else strobe_p_i = 1;
    step();
    idle();
  endtask

  task automatic t_reset();
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 active", 32'(active_o), 0);
    chk("R1 we", 32'(byte_we_o), 0);
  endtask

  task automatic t_load();
    load(18'h2ABC1, 0, 0);
    chk("R2 addr via strobe A", 32'(addr_o), 32'h2ABC1);
    chk("R2 active", 32'(active_o), 1);
    load(18'h01237, 0, 1);
    chk("R2 addr via strobe B", 32'(addr_o), 32'h01237);
  endtask

  task automatic t_back2back();
    logic [AW-1:0] seq [3] = '{18'h10000, 18'h00F03, 18'h3FFFE};
    idle();
    for (int i = 0; i < 3; i++) begin
      addr_i = seq[i]; strobe_p_i = 1; adv_i = 1;
      step();
      chk("R3 back-to-back load", 32'(addr_o), 32'(seq[i]));
    end
    idle();
  endtask

  task automatic t_deselect();
    load(18'h05554, 0, 0);
    addr_i = 18'h3AAAA; strobe_c_i = 1; en_b_i = 0;
    step();
    chk("R4 inactive", 32'(active_o), 0);
    chk("R4 addr held", 32'(addr_o), 32'h05554);
    idle();
    adv_i = 1;
    step(); step();
    chk("R8 adv ignored when inactive", 32'(addr_o), 32'h05554);
    idle();
  endtask

  task automatic t_burst(input logic lin, input logic [1:0] s, input string req);
    logic [AW-1:0] base = 18'h1F3C0;
    load(base | 18'(s), lin, 0);
    for (int k = 1; k <= 4; k++) begin
      logic [1:0] kk = 2'(k);
      logic [1:0] exp_lo = lin ? 2'(s + kk) : (s ^ kk);
      adv_i = 1;
      step();
      chk(req, 32'(addr_o[1:0]), 32'(exp_lo));
      chk("R7 upper fixed", 32'(addr_o[AW-1:2]), 32'(base[AW-1:2]));
    end
    chk("R7 wrap to start", 32'(addr_o[1:0]), 32'(s));
    idle();
  endtask

  task automatic t_hold();
    load(18'h00402, 1, 0);
    adv_i = 1; step();
    adv_i = 0; step(); step();
    chk("R8 hold without adv", 32'(addr_o), 32'h00403);
    idle();
  endtask

  task automatic t_order_latch();
    load(18'h00011, 1, 0);
    lin_order_i = 0; adv_i = 1;
    step();
    chk("R9 order latched at load", 32'(addr_o[1:0]), 2);
    idle();
  endtask

  task automatic t_writes();
    idle(); addr_i = 18'h00100; strobe_p_i = 1;
    wr_byte_i = 1; byte_sel_i = 2'b10;
    step();
    chk("R10 selected lanes only", 32'(byte_we_o), 32'b10);
    idle(); wr_byte_i = 1; byte_sel_i = 2'b01; adv_i = 1;
    step();
    chk("R10 lane during burst", 32'(byte_we_o), 32'b01);
    idle(); wr_all_i = 1;
    step();
    chk("R11 global write", 32'(byte_we_o), 32'b11);
    idle(); byte_sel_i = 2'b11;
    step();
    chk("R12 no write input", 32'(byte_we_o), 0);
    idle(); wr_all_i = 1; strobe_p_i = 1; en_c_ni = 1;
    step();
    chk("R12 deselect blocks write", 32'(byte_we_o), 0);
    idle(); wr_byte_i = 1; byte_sel_i = 2'b11;
    step();
    chk("R12 inactive blocks write", 32'(byte_we_o), 0);
    idle();
  endtask

  initial begin
    #2;
    step();
    t_reset();
    rst_ni = 1;
    step();
    t_load();
    t_back2back();
    t_deselect();
    t_burst(0, 2'd1, "R5 interleaved step");
    t_burst(0, 2'd2, "R5 interleaved step");
    t_burst(1, 2'd2, "R6 linear step");
    t_burst(1, 2'd3, "R6 linear step");
    t_hold();
    t_order_latch();
    t_writes();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule